// File: doc/BRIEF.md
# Power Mode Sequencer

This block steps a mixed-signal lighting chip through its power modes. It follows the external reset pin, the internal power-on reset, a thermal-shutdown flag and two control bits: the chip-active bit and the boost-enable bit. From these it decides when the register file is cleared, when the reference, bias and oscillator run, and when the boost converter switches and in which mode. All waits are counted in pulses of a one-millisecond tick that comes from outside, so the block itself holds no analog timing.

Leaving standby starts a settling wait for the oscillator. After that the chip either goes straight to its normal state or first runs the boost start-up. The boost start-up is two timed phases in a row: a quiet settling phase with the switch off, then a soft-start phase in pulse-frequency mode, and only then fixed-frequency PWM. A thermal event drops the chip back into the start-up state, not into reset, and holds it there. Clearing the chip-active bit returns to standby at once from any running state.

The power-on reset flag is also the synchronous reset of the block. The pin reset is synchronised and accepted only after it has been low for a minimum number of clock cycles. All inputs other than the pin reset are taken to be synchronous to `clk`.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `por_i` is high, or while an accepted pin reset is held, the block is in reset: `mode_o` = 0, `reg_rst_o` = 1, and `bias_en_o`, `osc_en_o`, `boost_en_o` and `boost_pwm_o` are all 0.
- R2: Once reset is released with `nstby_i` = 0, the block enters standby (`mode_o` = 1) with `reg_rst_o` and every enable at 0.
- R3: With `nstby_i` = 1 in standby, the block enters start-up (`mode_o` = 2) one clock later. `bias_en_o` and `osc_en_o` are 1 and `boost_en_o` is 0.
- R4: Start-up lasts exactly `DELAY_TICKS` tick pulses. On the last pulse it moves to the boost start-up (`mode_o` = 3) if `en_boost_i` = 1, and to normal (`mode_o` = 4) with the boost off otherwise.
- R5: Setting `en_boost_i` to 1 in normal with the boost idle enters boost start-up (`mode_o` = 3) one clock later. `boost_en_o` stays 0 for the first `DELAY_TICKS` ticks.
- R6: After the settling phase, `boost_en_o` = 1 and `boost_pwm_o` = 0 (PFM) for `DELAY_TICKS` ticks. Then the block enters normal (`mode_o` = 4) with `boost_en_o` = 1 and `boost_pwm_o` = 1 (PWM).
- R7: `en_boost_i` = 0 in normal or during boost start-up gives `mode_o` = 4, `boost_en_o` = 0 and `boost_pwm_o` = 0 one clock later, with the bias still on.
- R8: `thsd_i` = 1 in any running state gives start-up (`mode_o` = 2) with all enables at 0 one clock later. The block stays there while the flag is high. After the flag clears, a full `DELAY_TICKS` wait runs before start-up is left.
- R9: `nstby_i` = 0 in any running state gives standby (`mode_o` = 1) one clock later, with the bias and the boost off.
- R10: `nrst_pin_i` low for fewer than `MIN_LOW_CYCLES` synchronised cycles has no effect. A low lasting at least that long forces reset, and reset holds until the pin returns high.
- R11: `boost_pwm_o` is never 1 without `boost_en_o`, and PWM is only entered from an active PFM phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on reset flag, active high, synchronous reset of the block |
| nrst_pin_i | input | 1 | External reset pin, active low, asynchronous |
| thsd_i | input | 1 | Thermal shutdown flag, active high |
| nstby_i | input | 1 | Chip-active control bit (0 = standby) |
| en_boost_i | input | 1 | Boost enable control bit |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| reg_rst_o | output | 1 | Register file reset request |
| bias_en_o | output | 1 | Reference and bias enable |
| osc_en_o | output | 1 | Oscillator enable |
| boost_en_o | output | 1 | Boost converter switching enable |
| boost_pwm_o | output | 1 | Boost mode: 0 = PFM, 1 = PWM |
| mode_o | output | 3 | Mode code: 0 reset, 1 standby, 2 start-up, 3 boost start-up, 4 normal |

## Verification
The assertions check the safety relations on every cycle:
- PWM only with the boost on, and only after PFM.
- Nothing enabled while the register reset is driven.
- Bias and boost dropped one clock after a thermal event or a cleared chip-active bit.
- Boost off one clock after its enable bit clears.
- Mode codes always in the legal range.

Only the directed scenarios can show the lengths of the timed phases. These cover:
- the exact tick on which start-up and each boost phase end;
- the full restart of the wait after a thermal event;
- the path chosen out of start-up;
- the rejection of short reset-pin pulses against the acceptance of long ones.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_RESET      = 3'd0,
    ST_STANDBY    = 3'd1,
    ST_STARTUP    = 3'd2,
    ST_BST_SETTLE = 3'd3,
    ST_NORMAL     = 3'd4,
    ST_BST_PFM    = 3'd5
  } pwr_state_e;

  localparam logic [2:0] MODE_RESET   = 3'd0;
  localparam logic [2:0] MODE_STANDBY = 3'd1;
  localparam logic [2:0] MODE_STARTUP = 3'd2;
  localparam logic [2:0] MODE_BOOST   = 3'd3;
  localparam logic [2:0] MODE_NORMAL  = 3'd4;

  function automatic logic [2:0] mode_of(pwr_state_e st);
    case (st)
      ST_RESET:      return MODE_RESET;
      ST_STANDBY:    return MODE_STANDBY;
      ST_STARTUP:    return MODE_STARTUP;
      ST_BST_SETTLE: return MODE_BOOST;
      ST_BST_PFM:    return MODE_BOOST;
      ST_NORMAL:     return MODE_NORMAL;
      default:       return MODE_RESET;
    endcase
  endfunction

endpackage

// File: rtl/pwr_rst_filter.sv
module pwr_rst_filter #(
  parameter int SYNC_STAGES    = 2,
  parameter int MIN_LOW_CYCLES = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic nrst_async_i,
  output logic hold_o
);
  localparam int CNT_W = $clog2(MIN_LOW_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       low_cnt_q;
  logic                   pin_low;

  // synchroniser chain: stage 0 samples the pin, the last stage is used
  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b1;
    else     sync_q[0] <= nrst_async_i;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync_q[g] <= 1'b1;
      else     sync_q[g] <= sync_q[g-1];
    end
  end

  assign pin_low = ~sync_q[SYNC_STAGES-1];

  // pulse qualification: accept only a low level lasting MIN_LOW_CYCLES
  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt_q <= '0;
      hold_o    <= 1'b0;
    end else if (pin_low) begin
      if (!hold_o) begin
        if (low_cnt_q == CNT_W'(MIN_LOW_CYCLES - 1)) hold_o <= 1'b1;
        else                                         low_cnt_q <= low_cnt_q + 1'b1;
      end
    end else begin
      low_cnt_q <= '0;
      hold_o    <= 1'b0;
    end
  end

endmodule

// File: rtl/pwr_ms_delay.sv
module pwr_ms_delay #(
  parameter int DELAY_TICKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(DELAY_TICKS + 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && tick_i && (cnt_q == CNT_W'(DELAY_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst || clear_i)      cnt_q <= '0;
    else if (run_i && tick_i) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rst_hold_i,
  input  logic       thsd_i,
  input  logic       nstby_i,
  input  logic       en_boost_i,
  input  logic       delay_done_i,
  output logic       delay_clear_o,
  output logic       delay_run_o,
  output logic       reg_rst_o,
  output logic       bias_en_o,
  output logic       osc_en_o,
  output logic       boost_en_o,
  output logic       boost_pwm_o,
  output logic [2:0] mode_o
);
  pwr_state_e st_q, st_d;
  logic       up_q, up_d;
  logic       running_d;

  always_comb begin
    st_d = st_q;
    up_d = 1'b0;
    if (rst_hold_i) begin
      st_d = ST_RESET;
    end else if (st_q == ST_RESET) begin
      st_d = ST_STANDBY;
    end else if (!nstby_i) begin
      st_d = ST_STANDBY;
    end else if (thsd_i) begin
      st_d = ST_STARTUP;
    end else begin
      case (st_q)
        ST_STANDBY: st_d = ST_STARTUP;
        ST_STARTUP: begin
          if (delay_done_i) st_d = en_boost_i ? ST_BST_SETTLE : ST_NORMAL;
        end
        ST_BST_SETTLE: begin
          if (!en_boost_i)       st_d = ST_NORMAL;
          else if (delay_done_i) st_d = ST_BST_PFM;
        end
        ST_BST_PFM: begin
          if (!en_boost_i) st_d = ST_NORMAL;
          else if (delay_done_i) begin
            st_d = ST_NORMAL;
            up_d = 1'b1;
          end
        end
        ST_NORMAL: begin
          if (en_boost_i && !up_q) st_d = ST_BST_SETTLE;
          else                     up_d = up_q && en_boost_i;
        end
        default: st_d = ST_RESET;
      endcase
    end
  end

  assign delay_clear_o = (st_d != st_q) || thsd_i;
  assign delay_run_o   = !thsd_i && ((st_q == ST_STARTUP) || (st_q == ST_BST_SETTLE) ||
                                     (st_q == ST_BST_PFM));
  assign running_d     = (st_d == ST_STARTUP) || (st_d == ST_BST_SETTLE) ||
                         (st_d == ST_BST_PFM) || (st_d == ST_NORMAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_RESET;
      up_q        <= 1'b0;
      reg_rst_o   <= 1'b1;
      bias_en_o   <= 1'b0;
      osc_en_o    <= 1'b0;
      boost_en_o  <= 1'b0;
      boost_pwm_o <= 1'b0;
      mode_o      <= MODE_RESET;
    end else begin
      st_q        <= st_d;
      up_q        <= up_d;
      reg_rst_o   <= (st_d == ST_RESET);
      bias_en_o   <= running_d && !thsd_i;
      osc_en_o    <= running_d && !thsd_i;
      boost_en_o  <= (st_d == ST_BST_PFM) || ((st_d == ST_NORMAL) && up_d);
      boost_pwm_o <= (st_d == ST_NORMAL) && up_d;
      mode_o      <= mode_of(st_d);
    end
  end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int SYNC_STAGES    = 2,
  parameter int MIN_LOW_CYCLES = 2500,
  parameter int DELAY_TICKS    = 10
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       nrst_pin_i,
  input  logic       thsd_i,
  input  logic       nstby_i,
  input  logic       en_boost_i,
  input  logic       ms_tick_i,
  output logic       reg_rst_o,
  output logic       bias_en_o,
  output logic       osc_en_o,
  output logic       boost_en_o,
  output logic       boost_pwm_o,
  output logic [2:0] mode_o
);
  logic rst_hold;
  logic dly_clear, dly_run, dly_done;

  pwr_rst_filter #(
    .SYNC_STAGES   (SYNC_STAGES),
    .MIN_LOW_CYCLES(MIN_LOW_CYCLES)
  ) u_rst_filter (
    .clk         (clk),
    .rst         (por_i),
    .nrst_async_i(nrst_pin_i),
    .hold_o      (rst_hold)
  );

  pwr_ms_delay #(
    .DELAY_TICKS(DELAY_TICKS)
  ) u_delay (
    .clk    (clk),
    .rst    (por_i),
    .clear_i(dly_clear),
    .run_i  (dly_run),
    .tick_i (ms_tick_i),
    .done_o (dly_done)
  );

  pwr_mode_fsm u_fsm (
    .clk          (clk),
    .rst          (por_i),
    .rst_hold_i   (rst_hold),
    .thsd_i       (thsd_i),
    .nstby_i      (nstby_i),
    .en_boost_i   (en_boost_i),
    .delay_done_i (dly_done),
    .delay_clear_o(dly_clear),
    .delay_run_o  (dly_run),
    .reg_rst_o    (reg_rst_o),
    .bias_en_o    (bias_en_o),
    .osc_en_o     (osc_en_o),
    .boost_en_o   (boost_en_o),
    .boost_pwm_o  (boost_pwm_o),
    .mode_o       (mode_o)
  );

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk (
  input logic       clk,
  input logic       por_i,
  input logic       thsd_i,
  input logic       nstby_i,
  input logic       en_boost_i,
  input logic       reg_rst_o,
  input logic       bias_en_o,
  input logic       osc_en_o,
  input logic       boost_en_o,
  input logic       boost_pwm_o,
  input logic [2:0] mode_o
);

  p_quiet_in_reset_r1: assert property (@(posedge clk) disable iff (por_i)
    reg_rst_o |-> (!bias_en_o && !osc_en_o && !boost_en_o));

  p_pwm_needs_boost_r11: assert property (@(posedge clk) disable iff (por_i)
    boost_pwm_o |-> boost_en_o);

  p_pwm_after_pfm_r11: assert property (@(posedge clk) disable iff (por_i)
    $rose(boost_pwm_o) |-> ($past(boost_en_o) && !$past(boost_pwm_o)));

  p_boost_off_r7: assert property (@(posedge clk) disable iff (por_i)
    !en_boost_i |=> !boost_en_o);

  p_thermal_off_r8: assert property (@(posedge clk) disable iff (por_i)
    thsd_i |=> (!bias_en_o && !osc_en_o && !boost_en_o));

  p_standby_off_r9: assert property (@(posedge clk) disable iff (por_i)
    !nstby_i |=> (!bias_en_o && !boost_en_o));

  p_mode_legal_r2: assert property (@(posedge clk) disable iff (por_i)
    mode_o <= 3'd4);

endmodule

bind pwr_mode_seq pwr_mode_seq_chk u_chk (
  .clk        (clk),
  .por_i      (por_i),
  .thsd_i     (thsd_i),
  .nstby_i    (nstby_i),
  .en_boost_i (en_boost_i),
  .reg_rst_o  (reg_rst_o),
  .bias_en_o  (bias_en_o),
  .osc_en_o   (osc_en_o),
  .boost_en_o (boost_en_o),
  .boost_pwm_o(boost_pwm_o),
  .mode_o     (mode_o)
);

// File: tb/pwr_mode_seq_bench.sv
module pwr_mode_seq_bench;
  localparam int MIN_LOW = 8;
  localparam int DLY     = 10;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       nrst = 1'b1;
  logic       thsd = 1'b0;
  logic       nstby = 1'b0;
  logic       en_boost = 1'b0;
  logic       tick = 1'b0;
  logic       reg_rst, bias_en, osc_en, boost_en, boost_pwm;
  logic [2:0] mode;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pwr_mode_seq #(
    .SYNC_STAGES   (2),
    .MIN_LOW_CYCLES(MIN_LOW),
    .DELAY_TICKS   (DLY)
  ) u_pwr_mode_seq (
    .clk        (clk),
    .por_i      (por),
    .nrst_pin_i (nrst),
    .thsd_i     (thsd),
    .nstby_i    (nstby),
    .en_boost_i (en_boost),
    .ms_tick_i  (tick),
    .reg_rst_o  (reg_rst),
    .bias_en_o  (bias_en),
    .osc_en_o   (osc_en),
    .boost_en_o (boost_en),
    .boost_pwm_o(boost_pwm),
    .mode_o     (mode)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic outs(input string req, input int m, input int rr, input int bias,
                      input int bst, input int pwm);
    check(req, "mode", int'(mode), m);
    check(req, "reg_rst", int'(reg_rst), rr);
    check(req, "bias_en", int'(bias_en), bias);
    check(req, "osc_en", int'(osc_en), bias);
    check(req, "boost_en", int'(boost_en), bst);
    check(req, "boost_pwm", int'(boost_pwm), pwm);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      cycles(3);
    end
  endtask

  task automatic t_reset;
    cycles(3);
    outs("R1", 0, 1, 0, 0, 0);
    por = 1'b0;
    cycles(3);
    outs("R2", 1, 0, 0, 0, 0);
  endtask

  task automatic t_startup;
    nstby = 1'b1;
    cycles(1);
    outs("R3", 2, 0, 1, 0, 0);
    ticks(DLY - 1);
    check("R4", "mode before last tick", int'(mode), 2);
    ticks(1);
    outs("R4", 4, 0, 1, 0, 0);
  endtask

  task automatic t_boost_up;
    en_boost = 1'b1;
    cycles(1);
    outs("R5", 3, 0, 1, 0, 0);
    ticks(DLY - 1);
    check("R5", "boost_en in settle", int'(boost_en), 0);
    ticks(1);
    outs("R6", 3, 0, 1, 1, 0);
    ticks(DLY - 1);
    check("R6", "pwm in pfm phase", int'(boost_pwm), 0);
    ticks(1);
    outs("R6", 4, 0, 1, 1, 1);
  endtask

  task automatic t_thermal;
    thsd = 1'b1;
    cycles(1);
    outs("R8", 2, 0, 0, 0, 0);
    ticks(DLY + 5);
    check("R8", "held in startup", int'(mode), 2);
    thsd = 1'b0;
    cycles(1);
    outs("R8", 2, 0, 1, 0, 0);
    ticks(DLY - 1);
    check("R8", "full wait after clear", int'(mode), 2);
    ticks(1);
    outs("R4", 3, 0, 1, 0, 0);
  endtask

  task automatic t_boost_off;
    en_boost = 1'b0;
    cycles(1);
    outs("R7", 4, 0, 1, 0, 0);
    en_boost = 1'b1;
    cycles(1);
    check("R5", "mode", int'(mode), 3);
    ticks(DLY);
    check("R6", "pfm active", int'(boost_en), 1);
    en_boost = 1'b0;
    cycles(1);
    outs("R7", 4, 0, 1, 0, 0);
  endtask

  task automatic t_standby;
    en_boost = 1'b1;
    cycles(1);
    ticks(2 * DLY);
    outs("R6", 4, 0, 1, 1, 1);
    nstby = 1'b0;
    cycles(1);
    outs("R9", 1, 0, 0, 0, 0);
  endtask

  task automatic t_pin_reset;
    en_boost = 1'b0;
    nstby = 1'b1;
    cycles(2);
    check("R3", "mode", int'(mode), 2);
    nrst = 1'b0;
    cycles(MIN_LOW - 3);
    nrst = 1'b1;
    cycles(6);
    check("R10", "short pulse ignored, mode", int'(mode), 2);
    check("R10", "short pulse ignored, reg_rst", int'(reg_rst), 0);
    nrst = 1'b0;
    cycles(MIN_LOW + 6);
    outs("R10", 0, 1, 0, 0, 0);
    cycles(10);
    outs("R1", 0, 1, 0, 0, 0);
    nstby = 1'b0;
    nrst = 1'b1;
    cycles(6);
    outs("R2", 1, 0, 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_boost_up();
    t_thermal();
    t_boost_off();
    t_standby();
    t_pin_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule